// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block compares a 16-bit free-running counter against five programmable compare values. When the counter equals a channel's value, that channel changes its output pin and sets its status flag. Channels 2 to 5 each drive one pin, with a selectable action: none, toggle, clear or set. Channel 1 has no pin of its own. Instead, a mask and data pair lets it drive any subset of the five pins. When channel 1 acts on a pin, its value overrides whatever another channel does to that pin in the same cycle.

Software reaches the block through a byte-wide register bus with an address, a write strobe, a read strobe and byte data. Each compare value is written as two bytes. Writing the high byte arms a per-channel two-state machine. The state `CMP_ARMED` moves to `CMP_HELD` on a high-byte write. `CMP_HELD` moves back to `CMP_ARMED` on the next cycle, or stays in `CMP_HELD` if another high-byte write arrives. While a channel is in `CMP_HELD` its compare is suppressed, so a half-updated value cannot match. A force register fires any set of channels at once: each forced channel performs its pin action but does not set its flag.

Register map (byte addresses):

| Address | Contents |
|---|---|
| 2(n-1) | high byte of channel n's compare value |
| 2(n-1)+1 | low byte of channel n's compare value |
| 0x0A | mask |
| 0x0B | data |
| 0x0C | force |
| 0x0D | mode |
| 0x0E | flags |
| 0x10 | counter high byte |
| 0x11 | counter low byte |

Top module: `oc_unit`

## Requirements
- R1: The counter resets to 0 and advances by one on every clock. It reads at address 0x10 (high byte) and 0x11 (low byte).
- R2: Each compare value resets to 0xFFFF and reads back byte by byte at its two addresses.
- R3: A write to a compare high byte suppresses that channel's match in the following cycle. This holds even if the counter then equals the new value.
- R4: On a match, the pin change and the flag appear after the clock edge that ends the cycle in which the counter equalled the compare value.
- R5: The mode byte at 0x0D holds channel 2 in bits 1:0, channel 3 in bits 3:2, channel 4 in bits 5:4 and channel 5 in bits 7:6. The encodings are 00 no pin change, 01 toggle, 10 clear, 11 set. Channel k drives pin k-1.
- R6: When channel 1 acts, every pin i whose mask bit i is 1 takes data bit i. Pins whose mask bit is 0 are left to the other channels.
- R7: If channel 1 and another channel act on the same pin in the same cycle, channel 1's data bit wins.
- R8: Mask and data implement only bits 4:0. Bits 7:5 read as 0.
- R9: Writing the force byte at 0x0C acts in the write cycle. Bit 7 fires channel 1, bit 6 channel 2, down to bit 3 for channel 5. Bits 2:0 have no effect, and the force byte always reads as 0.
- R10: A forced action never sets a status flag.
- R11: The flags at 0x0E hold channel k in bit k-1. Writing 1 to a flag bit clears it. A match in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| oc_pins | output | 5 | Output compare pins, registered |

## Verification
The hardest states to reach from the ports are two exact-cycle coincidences: a high-byte write whose new value equals the counter in the very next cycle, and a flag-clear write that lands in the same cycle as a fresh match. The bench keeps its own count of clocks since reset, which must agree with the counter it reads back. From that count it chooses compare values relative to the current cycle, so the low and high byte writes place the suppressed cycle on the match. It then waits on its count to issue the clear in the match cycle. A table of forced actions sets up overlapping channel 1 and per-channel actions on the same pins without waiting for the counter.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 16;
    localparam int NUM_CH  = 5;
    localparam int ADDR_W  = 5;
    localparam int MODE_W  = 2 * (NUM_CH - 1);

    localparam logic [ADDR_W-1:0] A_MASK   = 5'h0A;
    localparam logic [ADDR_W-1:0] A_DATA   = 5'h0B;
    localparam logic [ADDR_W-1:0] A_FORCE  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_MODE   = 5'h0D;
    localparam logic [ADDR_W-1:0] A_FLAG   = 5'h0E;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 5'h10;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 5'h11;

    typedef enum logic [1:0] {
        PA_NONE   = 2'b00,
        PA_TOGGLE = 2'b01,
        PA_CLEAR  = 2'b10,
        PA_SET    = 2'b11
    } pin_act_e;

    typedef enum logic {
        CMP_ARMED = 1'b0,
        CMP_HELD  = 1'b1
    } cmp_state_e;

endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count == W'($past(count) + 1'b1)));

endmodule

// File: rtl/oc_channel.sv
module oc_channel import oc_pkg::*; #(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  count,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [BW-1:0] wdata,
    output logic [W-1:0]  cmp_val,
    output logic          hit
);

    localparam int HI_W = W - BW;

    cmp_state_e state, state_nx;

    // compare value storage, byte-writable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val <= '1;
        end else begin
            if (wr_hi) cmp_val[W-1:BW] <= wdata[HI_W-1:0];
            if (wr_lo) cmp_val[BW-1:0] <= wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CMP_ARMED;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = CMP_ARMED;
        unique case (state)
            CMP_ARMED: state_nx = wr_hi ? CMP_HELD : CMP_ARMED;
            CMP_HELD:  state_nx = wr_hi ? CMP_HELD : CMP_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        hit = 1'b0;
        unique case (state)
            CMP_ARMED: hit = (count == cmp_val);
            CMP_HELD:  hit = 1'b0;
        endcase
    end

    // R3
    hold_after_hiwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> !hit);

endmodule

// File: rtl/oc_pin_ctrl.sv
module oc_pin_ctrl import oc_pkg::*; #(
    parameter int N = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       act,
    input  logic [2*(N-1)-1:0] mode,
    input  logic [N-1:0]       mask,
    input  logic [N-1:0]       data,
    output logic [N-1:0]       pins
);

    logic [N-1:0] pins_nx;

    always_comb begin
        pins_nx = pins;
        for (int i = 1; i < N; i++) begin
            if (act[i]) begin
                unique case (pin_act_e'(mode[2*(i-1) +: 2]))
                    PA_NONE:   pins_nx[i] = pins[i];
                    PA_TOGGLE: pins_nx[i] = ~pins[i];
                    PA_CLEAR:  pins_nx[i] = 1'b0;
                    PA_SET:    pins_nx[i] = 1'b1;
                endcase
            end
        end
        // master channel applied last so it takes priority
        if (act[0]) pins_nx = (pins_nx & ~mask) | (data & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins <= '0;
        else        pins <= pins_nx;
    end

    // R6
    master_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act[0] |=> ((pins & $past(mask)) == ($past(data) & $past(mask))));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|act) |=> $stable(pins));

endmodule

// File: rtl/oc_unit.sv
module oc_unit import oc_pkg::*; #(
    parameter int CW = CNT_W,
    parameter int NC = NUM_CH,
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    output logic [NC-1:0] oc_pins
);

    localparam int MW  = 2 * (NC - 1);
    localparam int PAD = BW - NC;

    logic [CW-1:0] count;
    logic [CW-1:0] cmp_val [NC];
    logic [NC-1:0] hit;
    logic [NC-1:0] force_act;
    logic [NC-1:0] act;
    logic [NC-1:0] mask_q, data_q, flags_q, flag_clr;
    logic [MW-1:0] mode_q;

    oc_counter #(.W(CW)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    for (genvar k = 0; k < NC; k++) begin : g_ch
        localparam logic [AW-1:0] HI_ADDR = AW'(2 * k);
        localparam logic [AW-1:0] LO_ADDR = AW'(2 * k + 1);

        oc_channel #(.W(CW), .BW(BW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .count   (count),
            .wr_hi   (bus_wr && (bus_addr == HI_ADDR)),
            .wr_lo   (bus_wr && (bus_addr == LO_ADDR)),
            .wdata   (bus_wdata),
            .cmp_val (cmp_val[k]),
            .hit     (hit[k])
        );

        assign force_act[k] = bus_wr && (bus_addr == A_FORCE) && bus_wdata[BW-1-k];
    end

    assign act      = hit | force_act;
    assign flag_clr = (bus_wr && (bus_addr == A_FLAG)) ? bus_wdata[NC-1:0] : '0;

    oc_pin_ctrl #(.N(NC)) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .mode  (mode_q),
        .mask  (mask_q),
        .data  (data_q),
        .pins  (oc_pins)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            data_q <= '0;
            mode_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MASK) mask_q <= bus_wdata[NC-1:0];
            if (bus_addr == A_DATA) data_q <= bus_wdata[NC-1:0];
            if (bus_addr == A_MODE) mode_q <= bus_wdata[MW-1:0];
        end
    end

    // status flags: set by real matches, cleared by writing ones; set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | hit;
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int k = 0; k < NC; k++) begin
                if (bus_addr == AW'(2 * k))     bus_rdata = cmp_val[k][CW-1:BW];
                if (bus_addr == AW'(2 * k + 1)) bus_rdata = cmp_val[k][BW-1:0];
            end
            if (bus_addr == A_MASK)   bus_rdata = {{PAD{1'b0}}, mask_q};
            if (bus_addr == A_DATA)   bus_rdata = {{PAD{1'b0}}, data_q};
            if (bus_addr == A_MODE)   bus_rdata = mode_q;
            if (bus_addr == A_FLAG)   bus_rdata = {{PAD{1'b0}}, flags_q};
            if (bus_addr == A_CNT_HI) bus_rdata = count[CW-1:BW];
            if (bus_addr == A_CNT_LO) bus_rdata = count[BW-1:0];
        end
    end

    // R4
    flag_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((flags_q & $past(hit)) == $past(hit)));

    // R10
    no_forced_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flags_q & ~$past(flags_q) & ~$past(hit)) == '0));

endmodule

// File: tb/oc_unit_bench.sv
module oc_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] oc_pins;

    int total = 0;
    int bad   = 0;
    logic [15:0] tbc;

    always #10 clk = ~clk;

    oc_unit u_oc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .oc_pins   (oc_pins)
    );

    // bench count of clocks since reset (R1 model)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbc <= '0;
        else        tbc <= tbc + 16'd1;
    end

    // {preset, mode, mask, data, force, expected pins}
    localparam logic [47:0] FVEC [10] = '{
        48'h00_55_00_00_78_1E,
        48'h1F_AA_00_00_78_01,
        48'h00_FF_00_00_78_1E,
        48'h0A_00_00_00_78_0A,
        48'h00_FF_1E_00_F8_00,
        48'h15_55_03_02_F8_0A,
        48'h00_55_00_00_40_02,
        48'h1F_00_1F_05_80_05,
        48'h1F_55_1F_10_00_1F,
        48'h00_55_1F_1F_07_00
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write occupies that cycle; returns at the next negedge
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_cnt(input logic [15:0] t);
        while (tbc != t) @(negedge clk);
    endtask

    task automatic preset_pins(input logic [7:0] p);
        wr(5'h0A, 8'h1F);
        wr(5'h0B, p);
        wr(5'h0C, 8'h80);
    endtask

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v, h, l;
        logic [15:0] c, t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R1 pins at reset", {11'd0, oc_pins}, 16'h0000);
        rd(5'h00, h); rd(5'h01, l);
        check("R2 ch1 reset value", {h, l}, 16'hFFFF);
        rd(5'h09, l);
        check("R2 ch5 low reset", {8'd0, l}, 16'h00FF);
        rd(5'h0E, v);
        check("R11 flags at reset", {8'd0, v}, 16'h0000);
        rd(5'h0A, v);
        check("R8 mask at reset", {8'd0, v}, 16'h0000);
        rd(5'h10, h); rd(5'h11, l);
        check("R1 counter tracks clocks", {h, l}, tbc);

        // table of forced actions
        for (int i = 0; i < 10; i++) begin
            preset_pins(FVEC[i][47:40]);
            wr(5'h0D, FVEC[i][39:32]);
            wr(5'h0A, FVEC[i][31:24]);
            wr(5'h0B, FVEC[i][23:16]);
            wr(5'h0C, FVEC[i][15:8]);
            check($sformatf("R5 R6 R7 R9 force vector %0d", i), {11'd0, oc_pins}, {8'd0, FVEC[i][7:0]});
            rd(5'h0E, v);
            check($sformatf("R10 no flag from force %0d", i), {8'd0, v}, 16'h0000);
        end

        // real matches on channels 1..4 at the same count
        preset_pins(8'h00);
        wr(5'h0D, 8'h0F);
        wr(5'h0A, 8'h06);
        wr(5'h0B, 8'h02);
        c = tbc;
        t = c + 16'd20;
        for (int k = 0; k < 4; k++) begin
            wr(5'(2 * k + 1), t[7:0]);
            wr(5'(2 * k), t[15:8]);
        end
        wait_cnt(t);
        check("R4 no change during match cycle", {11'd0, oc_pins}, 16'h0000);
        @(negedge clk);
        check("R6 R7 master priority on match", {11'd0, oc_pins}, 16'h0002);
        rd(5'h0E, v);
        check("R4 R5 flags after match", {8'd0, v}, 16'h000F);
        wr(5'h0E, 8'h01);
        rd(5'h0E, v);
        check("R11 clear one flag", {8'd0, v}, 16'h000E);
        wr(5'h0E, 8'h0E);
        rd(5'h0E, v);
        check("R11 clear rest", {8'd0, v}, 16'h0000);

        // high-byte write suppresses the next cycle
        wr(5'h0D, 8'h0D);
        c = tbc;
        t = c + 16'd2;
        wr(5'h03, t[7:0]);
        wr(5'h02, t[15:8]);
        @(negedge clk);
        check("R3 suppressed pin", {11'd0, oc_pins}, 16'h0002);
        rd(5'h0E, v);
        check("R3 suppressed flag", {8'd0, v}, 16'h0000);
        c = tbc;
        t = c + 16'd3;
        wr(5'h03, t[7:0]);
        wr(5'h02, t[15:8]);
        wait_cnt(t + 16'd1);
        check("R4 R5 toggle after held cycle", {11'd0, oc_pins}, 16'h0000);
        rd(5'h0E, v);
        check("R4 flag after held cycle", {8'd0, v}, 16'h0002);
        wr(5'h0E, 8'h02);

        // clear in the same cycle as a match
        wr(5'h0D, 8'hCD);
        c = tbc;
        t = c + 16'd10;
        wr(5'h09, t[7:0]);
        wr(5'h08, t[15:8]);
        wait_cnt(t);
        rd(5'h0E, v);
        check("R11 flag clear before collision", {8'd0, v}, 16'h0000);
        wr(5'h0E, 8'h10);
        rd(5'h0E, v);
        check("R11 set wins over clear", {8'd0, v}, 16'h0010);
        check("R5 set mode ch5", {11'd0, oc_pins}, 16'h0010);
        wr(5'h0E, 8'h10);
        rd(5'h0E, v);
        check("R11 clear without match", {8'd0, v}, 16'h0000);

        // byte access, unimplemented bits, force readback
        wr(5'h07, 8'h34);
        wr(5'h06, 8'h12);
        rd(5'h06, h); rd(5'h07, l);
        check("R2 byte readback", {h, l}, 16'h1234);
        wr(5'h0A, 8'hFF);
        rd(5'h0A, v);
        check("R8 mask upper bits", {8'd0, v}, 16'h001F);
        wr(5'h0B, 8'hE0);
        rd(5'h0B, v);
        check("R8 data upper bits", {8'd0, v}, 16'h0000);
        wr(5'h0C, 8'hF8);
        rd(5'h0C, v);
        check("R9 force reads zero", {8'd0, v}, 16'h0000);
        rd(5'h10, h); rd(5'h11, l);
        check("R1 counter later", {h, l}, tbc);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule